// File: doc/BRIEF.md
# Lockable Translation Buffer

This block is a small fully associative translation buffer that maps a coprocessor's external memory window onto physical memory. Software fills it one entry at a time through a memory-mapped register port. It first stages a tag word, which holds a virtual page, a page-size code and a valid bit. It then stages a data word, which holds a physical page. A load strobe commits both words to the entry that the victim index names.

A lock register holds two small fields: a base index and a victim index. Entries below the base are treated as pinned, and a global flush leaves them untouched. The victim index selects the entry that a load writes and the entry that the read-back registers show. A per-entry flush invalidates every entry that covers the staged virtual page. A soft reset clears the whole table and reports completion through a status bit.

A separate lookup port translates a virtual address in the same cycle. It returns the physical address and a hit flag. Each entry compares only the address bits above its own page size.

Top module: `lktlb`

## Requirements
- R1: Reading offset 0x00 returns the major version in bits 7:4 and the minor version in bits 3:0. The defaults are major 1 and minor 2, so the value is 0x12; all other bits read 0.
- R2: Offset 0x50 is the lock register. It holds the base index in bits 12:10 and the victim index in bits 6:4, both 3 bits wide with the default 8 entries. A write sets both fields, and a read returns them with all other bits 0.
- R3: Staging works as follows:
  - Offset 0x58 stages the tag word: virtual page in bits 31:12, size code in bits 2:1, valid in bit 0.
  - Offset 0x5C stages the data word: physical page in bits 31:12.
  - Writing 0x54 with bit 0 set copies both staged words into the entry at the victim index.
  - Writing 0x54 with bit 0 clear changes nothing.
- R4: Offset 0x68 returns the tag word of the entry at the victim index, in the staged-tag layout with bits 11:3 reading 0. Offset 0x6C returns that entry's physical page in bits 31:12, with bits 11:0 reading 0.
- R5: A lookup hits when translation is enabled, the lookup valid input is high, and a valid entry matches the address above its page size:
  - Size code 0 is a 4 KB page and compares bits 31:12.
  - Size code 1 is a 64 KB page and compares bits 31:16.
  - Size codes 2 and 3 are 1 MB pages and compare bits 31:20.
  The physical address is the entry's page bits above the page size, joined with the virtual address bits below it. It appears in the same cycle. If several entries match, the lowest index wins.
- R6: On a miss, while translation is disabled, or while the lookup valid input is low, the hit flag is 0 and the physical address is 0.
- R7: Offset 0x44 controls translation. Writing a value with bit 1 set enables it, and writing 0x00 disables it. A read returns the enable in bit 1.
- R8: Writing 0x64 with bit 0 set invalidates every valid entry whose page, compared at that entry's own size, contains the staged tag's virtual page. When nothing matches, no entry changes.
- R9: Writing 0x60 with bit 0 set invalidates every entry whose index is at or above the lock base. Entries below the base keep their contents.
- R10: Writing 0x10 with bit 1 set starts a soft reset, which clears every entry, both lock fields, the enable and the staged words. Bit 0 of offset 0x14 then reads 0 for 4 cycles and 1 afterwards. Register writes made during that time are ignored.
- R11: After the reset input, every entry reads 0, the lock fields are 0, translation is disabled, and status bit 0 reads 1.
- R12: A lookup in the same cycle as a load sees the table as it was before the load. The loaded entry translates from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational on reg_addr |
| lk_valid | input | 1 | Lookup request valid |
| lk_vaddr | input | 32 | Virtual address to translate |
| lk_hit | output | 1 | Translation found |
| lk_paddr | output | 32 | Translated physical address, 0 on a miss |

## Verification
Two functions can land in the same cycle: a load commit from the register port and a lookup on the translation port. The bench drives the load strobe and a lookup of the page being loaded on the same clock. It checks that the lookup misses before the edge, because that entry was flushed earlier. It then checks that the same lookup hits with the new physical address one cycle later. A soft reset followed at once by an attempted control write checks that the busy window blocks register writes.

// File: rtl/lktlb_pkg.sv
package lktlb_pkg;

    localparam int ADDR_W   = 32;
    localparam int PG_SHIFT = 12;
    localparam int VPN_W    = ADDR_W - PG_SHIFT;

    // register byte offsets
    localparam logic [7:0] OFS_REV    = 8'h00;
    localparam logic [7:0] OFS_SYSCFG = 8'h10;
    localparam logic [7:0] OFS_STATUS = 8'h14;
    localparam logic [7:0] OFS_CTRL   = 8'h44;
    localparam logic [7:0] OFS_LOCK   = 8'h50;
    localparam logic [7:0] OFS_LOAD   = 8'h54;
    localparam logic [7:0] OFS_TAG    = 8'h58;
    localparam logic [7:0] OFS_DATA   = 8'h5C;
    localparam logic [7:0] OFS_GFLUSH = 8'h60;
    localparam logic [7:0] OFS_FLUSH  = 8'h64;
    localparam logic [7:0] OFS_RDTAG  = 8'h68;
    localparam logic [7:0] OFS_RDDATA = 8'h6C;

    localparam int LK_BASE_LSB = 10;
    localparam int LK_VICT_LSB = 4;

    typedef enum logic [1:0] {
        PG_4K   = 2'd0,
        PG_64K  = 2'd1,
        PG_1M   = 2'd2,
        PG_1M_B = 2'd3
    } pgsz_e;

    typedef struct packed {
        logic [VPN_W-1:0] vpn;
        pgsz_e            size;
        logic             valid;
    } tag_t;

    // page-number bits that take part in a compare for a given size
    function automatic logic [VPN_W-1:0] vpn_mask(pgsz_e sz);
        logic [VPN_W-1:0] ones;
        ones = '1;
        case (sz)
            PG_4K:   return ones;
            PG_64K:  return ones << 4;
            default: return ones << 8;
        endcase
    endfunction

    function automatic logic [ADDR_W-1:0] tag_word(tag_t t);
        return {t.vpn, {(ADDR_W-VPN_W-3){1'b0}}, t.size, t.valid};
    endfunction

endpackage

// File: rtl/lktlb_regs.sv
module lktlb_regs
    import lktlb_pkg::*;
#(
    parameter int IDX_W      = 3,
    parameter int REV_MAJOR  = 1,
    parameter int REV_MINOR  = 2,
    parameter int RST_CYCLES = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [7:0]        reg_addr,
    input  logic [ADDR_W-1:0] reg_wdata,
    output logic [ADDR_W-1:0] reg_rdata,
    input  tag_t              rd_tag,
    input  logic [VPN_W-1:0]  rd_ppn,
    output logic              en_o,
    output logic [IDX_W-1:0]  base_o,
    output logic [IDX_W-1:0]  victim_o,
    output tag_t              stage_tag_o,
    output logic [VPN_W-1:0]  stage_ppn_o,
    output logic              load_o,
    output logic              flush_one_o,
    output logic              flush_upper_o,
    output logic              clr_all_o
);

    localparam int CNT_W = $clog2(RST_CYCLES) + 1;

    logic             busy_q;
    logic [CNT_W-1:0] cnt_q;
    logic             en_q;
    logic [IDX_W-1:0] base_q, victim_q;
    tag_t             stag_q;
    logic [VPN_W-1:0] sppn_q;
    logic             wr_ok;

    assign wr_ok         = reg_wr && !busy_q;
    assign clr_all_o     = wr_ok && (reg_addr == OFS_SYSCFG) && reg_wdata[1];
    assign load_o        = wr_ok && (reg_addr == OFS_LOAD)   && reg_wdata[0];
    assign flush_one_o   = wr_ok && (reg_addr == OFS_FLUSH)  && reg_wdata[0];
    assign flush_upper_o = wr_ok && (reg_addr == OFS_GFLUSH) && reg_wdata[0];

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q   <= 1'b0;
            cnt_q    <= '0;
            en_q     <= 1'b0;
            base_q   <= '0;
            victim_q <= '0;
            stag_q   <= '0;
            sppn_q   <= '0;
        end else if (clr_all_o) begin
            busy_q   <= 1'b1;
            cnt_q    <= CNT_W'(RST_CYCLES - 1);
            en_q     <= 1'b0;
            base_q   <= '0;
            victim_q <= '0;
            stag_q   <= '0;
            sppn_q   <= '0;
        end else if (busy_q) begin
            if (cnt_q == '0) busy_q <= 1'b0;
            else             cnt_q  <= cnt_q - 1'b1;
        end else if (wr_ok) begin
            case (reg_addr)
                OFS_CTRL: en_q <= reg_wdata[1];
                OFS_LOCK: begin
                    base_q   <= reg_wdata[LK_BASE_LSB +: IDX_W];
                    victim_q <= reg_wdata[LK_VICT_LSB +: IDX_W];
                end
                OFS_TAG: begin
                    stag_q.vpn   <= reg_wdata[ADDR_W-1:PG_SHIFT];
                    stag_q.size  <= pgsz_e'(reg_wdata[2:1]);
                    stag_q.valid <= reg_wdata[0];
                end
                OFS_DATA: sppn_q <= reg_wdata[ADDR_W-1:PG_SHIFT];
                default: ;
            endcase
        end
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            OFS_REV:    reg_rdata[7:0] = {4'(REV_MAJOR), 4'(REV_MINOR)};
            OFS_STATUS: reg_rdata[0] = !busy_q;
            OFS_CTRL:   reg_rdata[1] = en_q;
            OFS_LOCK: begin
                reg_rdata[LK_BASE_LSB +: IDX_W] = base_q;
                reg_rdata[LK_VICT_LSB +: IDX_W] = victim_q;
            end
            OFS_TAG:    reg_rdata = tag_word(stag_q);
            OFS_DATA:   reg_rdata = {sppn_q, {PG_SHIFT{1'b0}}};
            OFS_RDTAG:  reg_rdata = tag_word(rd_tag);
            OFS_RDDATA: reg_rdata = {rd_ppn, {PG_SHIFT{1'b0}}};
            default:    reg_rdata = '0;
        endcase
    end

    assign en_o        = en_q;
    assign base_o      = base_q;
    assign victim_o    = victim_q;
    assign stage_tag_o = stag_q;
    assign stage_ppn_o = sppn_q;

    AST_SRST_BUSY: assert property (@(posedge clk) disable iff (rst)
        clr_all_o |=> busy_q);  // R10
    AST_SRST_LOCK: assert property (@(posedge clk) disable iff (rst)
        clr_all_o |=> (base_q == '0 && victim_q == '0 && !en_q));  // R10
    AST_LOCK_WRITE: assert property (@(posedge clk) disable iff (rst)
        (wr_ok && reg_addr == OFS_LOCK) |=>
            (victim_q == $past(reg_wdata[LK_VICT_LSB +: IDX_W])));  // R2

endmodule

// File: rtl/lktlb_array.sv
module lktlb_array
    import lktlb_pkg::*;
#(
    parameter int ENTRIES = 8,
    parameter int IDX_W   = 3
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         clr_all_i,
    input  logic                         load_i,
    input  logic [IDX_W-1:0]             load_idx_i,
    input  tag_t                         load_tag_i,
    input  logic [VPN_W-1:0]             load_ppn_i,
    input  logic                         flush_one_i,
    input  logic [VPN_W-1:0]             flush_vpn_i,
    input  logic                         flush_upper_i,
    input  logic [IDX_W-1:0]             base_i,
    output tag_t [ENTRIES-1:0]           tags_o,
    output logic [ENTRIES-1:0][VPN_W-1:0] ppns_o
);

    logic [ENTRIES-1:0] vld;
    logic [ENTRIES-1:0] keep;

    for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
        tag_t             t_q;
        logic [VPN_W-1:0] p_q;
        logic             fl_hit;

        assign fl_hit  = t_q.valid &&
                         (((t_q.vpn ^ flush_vpn_i) & vpn_mask(t_q.size)) == '0);
        assign keep[i] = (i < int'(base_i));

        always_ff @(posedge clk) begin
            if (rst || clr_all_i) begin
                t_q <= '0;
                p_q <= '0;
            end else if (load_i && (load_idx_i == IDX_W'(i))) begin
                t_q <= load_tag_i;
                p_q <= load_ppn_i;
            end else if (flush_one_i && fl_hit) begin
                t_q.valid <= 1'b0;
            end else if (flush_upper_i && !keep[i]) begin
                t_q.valid <= 1'b0;
            end
        end

        assign tags_o[i] = t_q;
        assign ppns_o[i] = p_q;
        assign vld[i]    = t_q.valid;
    end

    AST_LOAD_STORES: assert property (@(posedge clk) disable iff (rst)
        (load_i && !clr_all_i) |=> (tags_o[$past(load_idx_i)] == $past(load_tag_i)));  // R3
    AST_GFLUSH_KEEP: assert property (@(posedge clk) disable iff (rst)
        (flush_upper_i && !clr_all_i && !load_i && !flush_one_i) |=>
            ((vld & $past(keep)) == ($past(vld) & $past(keep))));  // R9
    AST_GFLUSH_CLEAR: assert property (@(posedge clk) disable iff (rst)
        flush_upper_i |=> ((vld & ~$past(keep)) == '0));  // R9
    AST_CLR_ALL: assert property (@(posedge clk) disable iff (rst)
        clr_all_i |=> (vld == '0));  // R10

endmodule

// File: rtl/lktlb_lookup.sv
module lktlb_lookup
    import lktlb_pkg::*;
#(
    parameter int ENTRIES = 8
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          en_i,
    input  logic                          lk_valid,
    input  logic [ADDR_W-1:0]             lk_vaddr,
    input  tag_t [ENTRIES-1:0]            tags_i,
    input  logic [ENTRIES-1:0][VPN_W-1:0] ppns_i,
    output logic                          lk_hit,
    output logic [ADDR_W-1:0]             lk_paddr
);

    logic [ENTRIES-1:0] match;
    logic               any;
    logic [VPN_W-1:0]   sel_ppn;
    pgsz_e              sel_sz;
    logic [ADDR_W-1:0]  pmask;

    for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
        assign match[i] = tags_i[i].valid &&
            (((tags_i[i].vpn ^ lk_vaddr[ADDR_W-1:PG_SHIFT]) & vpn_mask(tags_i[i].size)) == '0);
    end

    // descending scan so the lowest matching index is the last assignment
    always_comb begin
        any     = 1'b0;
        sel_ppn = '0;
        sel_sz  = PG_4K;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (match[i]) begin
                any     = 1'b1;
                sel_ppn = ppns_i[i];
                sel_sz  = tags_i[i].size;
            end
        end
    end

    assign pmask    = {vpn_mask(sel_sz), {PG_SHIFT{1'b0}}};
    assign lk_hit   = any && en_i && lk_valid;
    assign lk_paddr = lk_hit ? (({sel_ppn, {PG_SHIFT{1'b0}}} & pmask) | (lk_vaddr & ~pmask))
                             : '0;

    AST_HIT_GATED: assert property (@(posedge clk) disable iff (rst)
        lk_hit |-> (en_i && lk_valid));  // R6
    AST_MISS_ZERO: assert property (@(posedge clk) disable iff (rst)
        !lk_hit |-> (lk_paddr == '0));  // R6
    AST_HIT_HAS_MATCH: assert property (@(posedge clk) disable iff (rst)
        lk_hit |-> ($countones(match) > 0));  // R5

endmodule

// File: rtl/lktlb.sv
module lktlb
    import lktlb_pkg::*;
#(
    parameter int ENTRIES    = 8,
    parameter int REV_MAJOR  = 1,
    parameter int REV_MINOR  = 2,
    parameter int RST_CYCLES = 4
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        reg_wr,
    input  logic [7:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    input  logic        lk_valid,
    input  logic [31:0] lk_vaddr,
    output logic        lk_hit,
    output logic [31:0] lk_paddr
);

    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

    logic                          en;
    logic [IDX_W-1:0]              base, victim;
    tag_t                          stag;
    logic [VPN_W-1:0]              sppn;
    logic                          load, flush_one, flush_upper, clr_all;
    tag_t [ENTRIES-1:0]            tags;
    logic [ENTRIES-1:0][VPN_W-1:0] ppns;

    lktlb_regs #(
        .IDX_W(IDX_W), .REV_MAJOR(REV_MAJOR),
        .REV_MINOR(REV_MINOR), .RST_CYCLES(RST_CYCLES)
    ) u_regs (
        .clk(clk), .rst(rst),
        .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .rd_tag(tags[victim]), .rd_ppn(ppns[victim]),
        .en_o(en), .base_o(base), .victim_o(victim),
        .stage_tag_o(stag), .stage_ppn_o(sppn),
        .load_o(load), .flush_one_o(flush_one),
        .flush_upper_o(flush_upper), .clr_all_o(clr_all)
    );

    lktlb_array #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_array (
        .clk(clk), .rst(rst),
        .clr_all_i(clr_all),
        .load_i(load), .load_idx_i(victim),
        .load_tag_i(stag), .load_ppn_i(sppn),
        .flush_one_i(flush_one), .flush_vpn_i(stag.vpn),
        .flush_upper_i(flush_upper), .base_i(base),
        .tags_o(tags), .ppns_o(ppns)
    );

    lktlb_lookup #(.ENTRIES(ENTRIES)) u_lookup (
        .clk(clk), .rst(rst),
        .en_i(en), .lk_valid(lk_valid), .lk_vaddr(lk_vaddr),
        .tags_i(tags), .ppns_i(ppns),
        .lk_hit(lk_hit), .lk_paddr(lk_paddr)
    );

endmodule

// File: tb/lktlb_test.sv
`timescale 1ns/1ps
module lktlb_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        lk_valid = 1'b0;
    logic [31:0] lk_vaddr = '0;
    logic        lk_hit;
    logic [31:0] lk_paddr;

    int total = 0;
    int fails = 0;
    bit done  = 0;

    always #2.5 clk = ~clk;

    lktlb uut (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .lk_valid(lk_valid), .lk_vaddr(lk_vaddr),
        .lk_hit(lk_hit), .lk_paddr(lk_paddr)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b0; reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic look(input logic v, input logic [31:0] va);
        @(negedge clk);
        lk_valid = v; lk_vaddr = va;
        #1;
    endtask

    function automatic logic [31:0] lockw(int b, int v);
        return (32'(b) << 10) | (32'(v) << 4);
    endfunction

    function automatic logic [31:0] offm(int sz);
        return (sz == 0) ? 32'h0000_0FFF : (sz == 1) ? 32'h0000_FFFF : 32'h000F_FFFF;
    endfunction

    function automatic logic [31:0] va_of(int i);
        return 32'h1000_0000 + 32'(i) * 32'h0010_0000;
    endfunction

    function automatic logic [31:0] pa_of(int i);
        return 32'h8000_0000 + 32'(i) * 32'h0020_0000;
    endfunction

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++; fails++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        logic [31:0] va, exp_pa;
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        // reset state
        rd(8'h00, d); chk("R1 revision", d, 32'h12);
        rd(8'h14, d); chk("R11 status", d, 32'h1);
        rd(8'h44, d); chk("R11 control", d, 32'h0);
        rd(8'h50, d); chk("R11 lock", d, 32'h0);
        for (int i = 0; i < 8; i++) begin
            wr(8'h50, lockw(0, i));
            rd(8'h68, d); chk("R11 entry tag", d, 32'h0);
        end

        // lock field sweep
        for (int b = 0; b < 8; b++) begin
            wr(8'h50, lockw(b, 7 - b));
            rd(8'h50, d); chk("R2 lock readback", d, lockw(b, 7 - b));
        end

        // load strobe with bit 0 clear does nothing (R3)
        wr(8'h50, lockw(0, 0));
        wr(8'h58, va_of(0) | 32'h1);
        wr(8'h5C, pa_of(0));
        wr(8'h54, 32'h0);
        rd(8'h68, d); chk("R3 load with bit0 clear", d, 32'h0);

        // fill all entries, size code i%3
        for (int i = 0; i < 8; i++) begin
            wr(8'h50, lockw(0, i));
            wr(8'h58, va_of(i) | (32'(i % 3) << 1) | 32'h1);
            wr(8'h5C, pa_of(i));
            wr(8'h54, 32'h1);
        end
        for (int i = 0; i < 8; i++) begin
            wr(8'h50, lockw(0, i));
            rd(8'h68, d); chk("R3 R4 tag readback", d, va_of(i) | (32'(i % 3) << 1) | 32'h1);
            rd(8'h6C, d); chk("R3 R4 data readback", d, pa_of(i));
        end

        // disabled: no hit
        look(1'b1, va_of(3));
        chk("R6 disabled hit", {31'b0, lk_hit}, 32'h0);
        chk("R6 disabled paddr", lk_paddr, 32'h0);

        wr(8'h44, 32'h2);
        rd(8'h44, d); chk("R7 enable readback", d, 32'h2);

        for (int i = 0; i < 8; i++) begin
            va = va_of(i) | (32'h000F_EDCB & offm(i % 3));
            exp_pa = (pa_of(i) & ~offm(i % 3)) | (va & offm(i % 3));
            look(1'b1, va);
            chk("R5 hit", {31'b0, lk_hit}, 32'h1);
            chk("R5 paddr", lk_paddr, exp_pa);
        end
        look(1'b1, va_of(0) | 32'h1000);
        chk("R6 4KB neighbour miss", {31'b0, lk_hit}, 32'h0);
        chk("R6 miss paddr", lk_paddr, 32'h0);
        look(1'b1, va_of(1) | 32'h1_0000);
        chk("R6 64KB neighbour miss", {31'b0, lk_hit}, 32'h0);
        look(1'b0, va_of(2));
        chk("R6 valid low", {31'b0, lk_hit}, 32'h0);

        wr(8'h44, 32'h0);
        rd(8'h44, d); chk("R7 disable readback", d, 32'h0);
        look(1'b1, va_of(2));
        chk("R7 disabled no hit", {31'b0, lk_hit}, 32'h0);
        wr(8'h44, 32'h2);

        // single flush of entry 2 (1MB page) via an address inside it
        wr(8'h58, va_of(2) | 32'h0003_4000);
        wr(8'h64, 32'h1);
        look(1'b1, va_of(2));
        chk("R8 flushed entry misses", {31'b0, lk_hit}, 32'h0);
        wr(8'h58, 32'h7000_0000);
        wr(8'h64, 32'h1);
        for (int i = 0; i < 8; i++) begin
            wr(8'h50, lockw(0, i));
            rd(8'h68, d); chk("R8 valid after flushes", {31'b0, d[0]}, (i == 2) ? 32'h0 : 32'h1);
        end

        // global flush with base 4
        wr(8'h50, lockw(4, 0));
        wr(8'h60, 32'h1);
        for (int i = 0; i < 8; i++) begin
            wr(8'h50, lockw(4, i));
            rd(8'h68, d);
            chk("R9 valid after global flush", {31'b0, d[0]}, (i < 4 && i != 2) ? 32'h1 : 32'h0);
        end
        look(1'b1, va_of(1));
        chk("R9 locked entry still hits", {31'b0, lk_hit}, 32'h1);

        // load and lookup in the same cycle
        wr(8'h50, lockw(4, 5));
        wr(8'h58, va_of(5) | 32'h5);
        wr(8'h5C, 32'h9000_0000);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 8'h54; reg_wdata = 32'h1;
        lk_valid = 1'b1; lk_vaddr = va_of(5) | 32'h0001_2345;
        #1;
        chk("R12 same-cycle miss", {31'b0, lk_hit}, 32'h0);
        @(negedge clk);
        reg_wr = 1'b0;
        #1;
        chk("R12 next-cycle hit", {31'b0, lk_hit}, 32'h1);
        chk("R12 next-cycle paddr", lk_paddr, 32'h9001_2345);

        // soft reset
        wr(8'h10, 32'h2);
        rd(8'h14, d); chk("R10 busy status", d, 32'h0);
        wr(8'h44, 32'h2);
        repeat (6) @(negedge clk);
        rd(8'h14, d); chk("R10 done status", d, 32'h1);
        rd(8'h44, d); chk("R10 write during busy ignored", d, 32'h0);
        rd(8'h50, d); chk("R10 lock cleared", d, 32'h0);
        for (int i = 0; i < 8; i++) begin
            wr(8'h50, lockw(0, i));
            rd(8'h68, d); chk("R10 entry cleared", d, 32'h0);
        end

        done = 1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule